// File: doc/BRIEF.md
# Page Write Collector with In-Page Wrap

This block gathers the data bytes of one write instruction aimed at a byte-addressed nonvolatile array. It holds them for a single page of sixteen bytes, then commits them as one timed programming cycle. An upstream serial-bus decoder supplies the starting address with a load strobe and then one strobe per received byte. A commit request, raised when the bus transaction closes, starts the programming cycle. Each byte lands in the slot picked by the low four address bits. Only those bits advance, and they wrap inside the page, so when more than sixteen bytes arrive the most recent sixteen are the ones kept.

On commit the block samples the write-protect input once. It raises busy for a fixed number of clock cycles set by a parameter. During the first sixteen of those cycles it walks the slots and drives the array write port for every slot that holds a byte. Pages in the upper half of the array (address bit 8 set) are skipped when the sampled protect level was high. While busy, every other request is dropped. The address pointer output always shows the address that follows the last byte accepted, which the surrounding logic uses for current-address reads.

Top module: `page_wbuf_top`

## Requirements
- R1: After reset, busy is 0, the address pointer is 0x000 and the array write enable is 0.
- R2: A load strobe while idle sets the address pointer to the loaded 9-bit address and discards every byte collected before it.
- R3: A data strobe while idle stores the byte for the array address formed by the current page (pointer bits 8:4) and offset (bits 3:0), then advances only the offset by one. Bits 8:4 of the pointer never change on a data strobe.
- R4: The offset wraps from 15 to 0 in the same page. After a byte is stored at offset 15, the pointer shows offset 0 of that page.
- R5: When more than 16 bytes arrive before a commit, each offset holds the latest byte stored there, so the last 16 bytes sent are the ones written.
- R6: The array is written only after a commit. A commit writes exactly the offsets that received a byte, and every other address keeps its contents.
- R7: A commit accepted while idle with at least one byte collected raises busy in the next cycle and holds it high for exactly WR_CYCLES cycles.
- R8: The protect input is sampled on the commit cycle. If it was 1 and the page has address bit 8 set (0x100 to 0x1FF), nothing is written. Pages in the lower half are written whatever the protect level.
- R9: Changing the protect input while busy neither stops nor alters the write in progress.
- R10: An abort while idle drops all collected bytes without touching the array, so a later commit has nothing to write and busy stays 0.
- R11: Data strobes, load strobes, commits and aborts that arrive while busy have no effect. The pointer is unchanged and no byte is collected.
- R12: Array writes happen only while busy, at most one per cycle, and all writes of one commit target the same page.
- R13: Requests that arrive in the same idle cycle resolve by priority: abort, then commit, then load, then data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_stb | input | 1 | Load a new start address |
| load_addr | input | 9 | Start address for the load strobe |
| data_stb | input | 1 | One received data byte is valid |
| data_in | input | 8 | Received data byte |
| commit | input | 1 | Start the programming cycle |
| wp | input | 1 | Write protect for the upper half, sampled at commit |
| abort | input | 1 | Drop all collected bytes |
| busy | output | 1 | Programming cycle in progress |
| addr_ptr | output | 9 | Address following the last accepted byte |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | 9 | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
On every cycle the assertions check several properties. The length of each busy window must be exactly WR_CYCLES. Array writes must occur only inside that window, stay within one page, and never reach the protected half when the level sampled at commit was high. The pointer must stay still while busy. Which bytes end up in the array can only be shown by the bench's scenarios, because it depends on the history of strobes. This covers wrap, the last 16 bytes winning over earlier ones, aborts, and requests dropped while busy. The bench compares the whole array model against its own expected image after every commit.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef enum logic {
    PWB_IDLE = 1'b0,
    PWB_PROG = 1'b1
  } pwb_state_e;
endpackage

// File: rtl/pwb_slots.sv
module pwb_slots #(
  parameter int DATA_W = 8,
  parameter int OFF_W  = 4,
  localparam int SLOTS = 1 << OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr,
  input  logic [OFF_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              any_valid
);
  logic [DATA_W-1:0] data_vec [SLOTS];
  logic [SLOTS-1:0]  valid_vec;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic [DATA_W-1:0] byte_q;
    logic              vld_q;
    logic              vld_d;
    logic              hit;

    assign hit = wr_en && (wr_idx == OFF_W'(g));

    always_comb begin
      vld_d = vld_q;
      if (clr)      vld_d = 1'b0;
      else if (hit) vld_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_q <= 1'b0;
      else        vld_q <= vld_d;
    end

    always_ff @(posedge clk) begin
      if (hit) byte_q <= wr_data;
    end

    assign data_vec[g]  = byte_q;
    assign valid_vec[g] = vld_q;
  end

  assign rd_data   = data_vec[rd_idx];
  assign rd_valid  = valid_vec[rd_idx];
  assign any_valid = |valid_vec;
endmodule

// File: rtl/pwb_ptr.sv
module pwb_ptr #(
  parameter int ADDR_W = 9,
  parameter int OFF_W  = 4,
  localparam int PAGE_W = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              step_en,
  output logic [PAGE_W-1:0] page,
  output logic [OFF_W-1:0]  off
);
  logic [PAGE_W-1:0] page_d;
  logic [OFF_W-1:0]  off_d;

  always_comb begin
    page_d = page;
    off_d  = off;
    if (load_en) begin
      page_d = load_addr[ADDR_W-1:OFF_W];
      off_d  = load_addr[OFF_W-1:0];
    end else if (step_en) begin
      off_d  = off + OFF_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page <= '0;
      off  <= '0;
    end else begin
      page <= page_d;
      off  <= off_d;
    end
  end
endmodule

// File: rtl/pwb_timer.sv
module pwb_timer
  import pwb_pkg::*;
#(
  parameter int WR_CYCLES = 40,
  parameter int OFF_W     = 4,
  localparam int SLOTS  = 1 << OFF_W,
  localparam int CNT_W  = $clog2(WR_CYCLES + 1),
  localparam int SCAN_W = OFF_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             wp_in,
  output logic             busy,
  output logic             wp_held,
  output logic [OFF_W-1:0] scan_idx,
  output logic             scan_live,
  output logic             done
);
  pwb_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [SCAN_W-1:0] scan_q, scan_d;
  logic              wp_d;

  assign busy      = (state_q == PWB_PROG);
  assign done      = busy && (cnt_q == '0);
  assign scan_live = busy && (scan_q < SCAN_W'(SLOTS));
  assign scan_idx  = scan_q[OFF_W-1:0];

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    scan_d  = scan_q;
    wp_d    = wp_held;
    unique case (state_q)
      PWB_IDLE: begin
        if (start) begin
          state_d = PWB_PROG;
          cnt_d   = CNT_W'(WR_CYCLES - 1);
          scan_d  = '0;
          wp_d    = wp_in;
        end
      end
      PWB_PROG: begin
        if (scan_live) scan_d = scan_q + SCAN_W'(1);
        if (cnt_q == '0) state_d = PWB_IDLE;
        else             cnt_d   = cnt_q - CNT_W'(1);
      end
      default: state_d = PWB_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PWB_IDLE;
      cnt_q   <= '0;
      scan_q  <= '0;
      wp_held <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      scan_q  <= scan_d;
      wp_held <= wp_d;
    end
  end
endmodule

// File: rtl/page_wbuf_top.sv
module page_wbuf_top #(
  parameter int ADDR_W    = 9,
  parameter int DATA_W    = 8,
  parameter int OFF_W     = 4,
  parameter int WR_CYCLES = 40,
  localparam int PAGE_W = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_stb,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              data_stb,
  input  logic [DATA_W-1:0] data_in,
  input  logic              commit,
  input  logic              wp,
  input  logic              abort,
  output logic              busy,
  output logic [ADDR_W-1:0] addr_ptr,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  logic              idle;
  logic              abort_acc, commit_acc, load_acc, data_acc;
  logic              any_valid, rd_valid, wp_held, scan_live, done;
  logic [OFF_W-1:0]  scan_idx, off;
  logic [PAGE_W-1:0] page;
  logic [DATA_W-1:0] rd_data;
  logic              protected_pg;

  assign idle       = !busy;
  assign abort_acc  = idle && abort;
  assign commit_acc = idle && !abort && commit && any_valid;
  assign load_acc   = idle && !abort && !commit && load_stb;
  assign data_acc   = idle && !abort && !commit && !load_stb && data_stb;

  pwb_ptr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (load_acc),
    .load_addr (load_addr),
    .step_en   (data_acc),
    .page      (page),
    .off       (off)
  );

  pwb_slots #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_slots (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (data_acc),
    .wr_idx    (off),
    .wr_data   (data_in),
    .clr       (abort_acc || load_acc || done),
    .rd_idx    (scan_idx),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .any_valid (any_valid)
  );

  pwb_timer #(.WR_CYCLES(WR_CYCLES), .OFF_W(OFF_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (commit_acc),
    .wp_in     (wp),
    .busy      (busy),
    .wp_held   (wp_held),
    .scan_idx  (scan_idx),
    .scan_live (scan_live),
    .done      (done)
  );

  assign protected_pg = wp_held && page[PAGE_W-1];
  assign addr_ptr     = {page, off};
  assign mem_we       = scan_live && rd_valid && !protected_pg;
  assign mem_addr     = {page, scan_idx};
  assign mem_wdata    = rd_data;
endmodule

// File: rtl/pwb_checker.sv
module pwb_checker #(
  parameter int ADDR_W    = 9,
  parameter int OFF_W     = 4,
  parameter int WR_CYCLES = 40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              commit,
  input logic              abort,
  input logic              wp,
  input logic              busy,
  input logic [ADDR_W-1:0] addr_ptr,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr
);
  logic [31:0] run_len;
  logic        wp_cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_len <= '0;
      wp_cap  <= 1'b0;
    end else begin
      run_len <= busy ? run_len + 32'd1 : 32'd0;
      if (!busy && commit && !abort) wp_cap <= wp;
    end
  end

  assert_busy_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run_len == 32'(WR_CYCLES));

  assert_busy_max_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> run_len < 32'(WR_CYCLES));

  assert_we_in_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  assert_page_fixed_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |->
      mem_addr[ADDR_W-1:OFF_W] == $past(mem_addr[ADDR_W-1:OFF_W]));

  assert_protect_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !(mem_addr[ADDR_W-1] && wp_cap));

  assert_ptr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(addr_ptr));
endmodule

bind page_wbuf_top pwb_checker #(
  .ADDR_W(ADDR_W), .OFF_W(OFF_W), .WR_CYCLES(WR_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .commit(commit), .abort(abort), .wp(wp),
  .busy(busy), .addr_ptr(addr_ptr), .mem_we(mem_we), .mem_addr(mem_addr)
);

// File: tb/sim_page_wbuf_top.sv
module sim_page_wbuf_top;
  localparam int WRC = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load_stb = 1'b0, data_stb = 1'b0, commit = 1'b0, wp = 1'b0, abort = 1'b0;
  logic [8:0] load_addr = '0;
  logic [7:0] data_in = '0;
  logic       busy, mem_we;
  logic [8:0] addr_ptr, mem_addr;
  logic [7:0] mem_wdata;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  logic [7:0] mem [512];
  logic [7:0] expm [512];
  logic [7:0] pend [16];
  bit   [15:0] pval;
  logic [4:0] bpage = '0;
  logic [3:0] boff = '0;
  logic [4:0] mon_page = '0;

  always #10 clk = ~clk;

  page_wbuf_top #(.WR_CYCLES(WRC)) u0 (
    .clk(clk), .rst_n(rst_n), .load_stb(load_stb), .load_addr(load_addr),
    .data_stb(data_stb), .data_in(data_in), .commit(commit), .wp(wp),
    .abort(abort), .busy(busy), .addr_ptr(addr_ptr), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // R12 monitor: every write is inside the busy window and on the committed page
  always @(negedge clk) begin
    if (rst_n && mem_we)
      chk(busy && mem_addr[8:4] == mon_page, "R12 write window/page",
          {busy, mem_addr}, {1'b1, mon_page, 4'h0});
  end

  task automatic do_load(input logic [8:0] a);
    load_stb = 1; load_addr = a; @(negedge clk); load_stb = 0;
    bpage = a[8:4]; boff = a[3:0]; pval = '0;
  endtask

  task automatic do_data(input logic [7:0] d);
    data_stb = 1; data_in = d; @(negedge clk); data_stb = 0;
    pend[boff] = d; pval[boff] = 1'b1; boff = boff + 4'd1;
  endtask

  task automatic do_abort();
    abort = 1; @(negedge clk); abort = 0; pval = '0;
  endtask

  function automatic bit model_commit(input bit wpv);
    bit any = (pval != 0);
    if (any && !(wpv && bpage[4]))
      for (int i = 0; i < 16; i++)
        if (pval[i]) expm[{bpage, 4'(i)}] = pend[i];
    pval = '0;
    return any;
  endfunction

  task automatic cmp_mem(input string req);
    int bad = 0, first = -1;
    for (int i = 0; i < 512; i++)
      if (mem[i] !== expm[i]) begin bad++; if (first < 0) first = i; end
    if (first < 0) chk(1, req, 0, 0);
    else chk(0, req, {first, mem[first]}, {first, expm[first]});
  endtask

  task automatic wait_busy(output int cnt);
    cnt = 0;
    while (busy && cnt < 1000) begin cnt++; @(negedge clk); end
  endtask

  task automatic do_commit(input bit wpv, input bit flip, input string req);
    int cnt;
    bit any;
    mon_page = bpage;
    wp = wpv; commit = 1; @(negedge clk); commit = 0;
    if (flip) wp = ~wpv;
    any = model_commit(wpv);
    wait_busy(cnt);
    chk(cnt == (any ? WRC : 0), "R7 busy length", cnt, any ? WRC : 0);
    @(negedge clk);
    cmp_mem(req);
    chk(addr_ptr == {bpage, boff}, "R3 pointer after commit", addr_ptr, {bpage, boff});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int cnt;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 512; i++) begin mem[i] = 8'h00; expm[i] = 8'h00; end
    pval = '0;
    repeat (3) @(negedge clk);
    // R1
    chk(busy == 0 && addr_ptr == 0 && mem_we == 0, "R1 reset state",
        {busy, mem_we, addr_ptr}, 0);
    rst_n = 1; @(negedge clk);

    // R2, R3
    do_load(9'h05a);
    chk(addr_ptr == 9'h05a, "R2 load pointer", addr_ptr, 9'h05a);
    do_data(8'h11); do_data(8'h22); do_data(8'h33);
    chk(addr_ptr == 9'h05d, "R3 offset advance", addr_ptr, 9'h05d);
    cmp_mem("R6 array untouched before commit");
    do_commit(0, 0, "R6 byte commit");

    // R2: load drops earlier bytes
    do_load(9'h070); do_data(8'hee);
    do_load(9'h080); do_data(8'h5a);
    do_commit(0, 0, "R2 load discards bytes");

    // R4 wrap inside the page
    do_load(9'h1fe); do_data(8'ha1); do_data(8'ha2); do_data(8'ha3);
    chk(addr_ptr == 9'h1f1, "R4 wrap pointer", addr_ptr, 9'h1f1);
    do_commit(0, 0, "R4 wrap commit");
    do_load(9'h0cf); do_data(8'h77);
    chk(addr_ptr == 9'h0c0, "R4 last byte to first", addr_ptr, 9'h0c0);
    do_commit(0, 0, "R4 last byte commit");

    // R5 last 16 win
    do_load(9'h0e8);
    for (int i = 0; i < 20; i++) do_data(8'(8'h40 + i));
    chk(addr_ptr == 9'h0ec, "R5 pointer after 20 bytes", addr_ptr, 9'h0ec);
    do_commit(0, 0, "R5 last sixteen win");

    // R8 protection
    do_load(9'h120); do_data(8'hc1); do_data(8'hc2);
    do_commit(1, 0, "R8 upper half protected");
    do_load(9'h020); do_data(8'hd1); do_data(8'hd2);
    do_commit(1, 0, "R8 lower half writable");

    // R9 protect level held across the write
    do_load(9'h130); do_data(8'he1); do_data(8'he2);
    do_commit(0, 1, "R9 rising protect ignored");
    do_load(9'h140); do_data(8'hf1);
    do_commit(1, 1, "R9 falling protect ignored");

    // R10 abort
    do_load(9'h150); do_data(8'h99); do_data(8'h98);
    do_abort();
    do_commit(0, 0, "R10 abort drops bytes");

    // R13 abort beats commit in the same cycle
    do_load(9'h160); do_data(8'h61);
    abort = 1; commit = 1; @(negedge clk); abort = 0; commit = 0; pval = '0;
    chk(busy == 0, "R13 abort over commit", busy, 0);
    // R13 load beats data in the same cycle
    load_stb = 1; load_addr = 9'h034; data_stb = 1; data_in = 8'h3c;
    @(negedge clk); load_stb = 0; data_stb = 0;
    bpage = 5'h03; boff = 4'h4; pval = '0;
    chk(addr_ptr == 9'h034, "R13 load over data", addr_ptr, 9'h034);
    do_commit(0, 0, "R13 no byte from dropped strobe");

    // R11 requests while busy are ignored
    do_load(9'h0a3); do_data(8'h12); do_data(8'h34);
    mon_page = bpage;
    commit = 1; @(negedge clk); commit = 0;
    void'(model_commit(0));
    data_stb = 1; data_in = 8'hbb; @(negedge clk); data_stb = 0;
    load_stb = 1; load_addr = 9'h1c7; @(negedge clk); load_stb = 0;
    abort = 1; @(negedge clk); abort = 0;
    commit = 1; @(negedge clk); commit = 0;
    chk(addr_ptr == 9'h0a5, "R11 pointer held while busy", addr_ptr, 9'h0a5);
    wait_busy(cnt);
    chk(cnt == WRC - 4, "R11 commit while busy no extension", cnt, WRC - 4);
    @(negedge clk);
    cmp_mem("R11 busy commit result");
    do_commit(0, 0, "R11 no byte kept from busy strobe");

    // constrained random mix
    for (int it = 0; it < 60; it++) begin
      int nb = 1 + ($urandom % 36);
      do_load(9'($urandom));
      for (int k = 0; k < nb; k++) do_data(8'($urandom));
      if (($urandom % 8) == 0) do_abort();
      do_commit(1'($urandom), 1'($urandom), "R6 random commit");
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule